// File: doc/BRIEF.md
# DRAM Refresh Row Counter with Selectable Terminal Count

This block keeps the row address that the next DRAM refresh cycle should visit. A single-step command runs one refresh cycle. A burst command runs refresh cycles back to back until the row equal to the selected terminal count has been refreshed, and then stops without further input. Each refresh cycle lasts a fixed number of clocks, set by a parameter. During that time the block raises a strobe request and holds the row value steady. After the cycle ends the row moves on by one. After the terminal row it wraps to zero.

The terminal count can be 127, 255 or 511, and a setup command picks it from a two-bit select input. An active-low status flag goes low while the terminal row is being refreshed. A separate active-low clear input sets the row back to zero and cancels any refresh in progress. Row multiplexing and the strobe drivers belong to the surrounding controller.

Top module: `refresh_row_counter`

## Requirements
- R1: After a synchronous reset, row_o is 0, strobe_o and done_o are 0, eoc_n_o is 1, and the terminal count is 127.
- R2: A step command (cmd_i = 01) accepted while idle raises strobe_o for exactly CYC_CLKS cycles with row_o held constant. row_o then advances by one, in the cycle strobe_o falls.
- R3: A setup command (cmd_i = 11) accepted while idle loads the terminal count from sel_i: 00 gives 127, 01 gives 255, 10 or 11 gives 511.
- R4: eoc_n_o is 0 exactly during the refresh cycles whose row equals the terminal count, and 1 at all other times.
- R5: When the refresh of the terminal row completes, row_o becomes 0.
- R6: A burst command (cmd_i = 10) accepted while idle refreshes consecutive rows with no idle gap, keeping strobe_o high, until the terminal row has been refreshed. It then drops strobe_o and pulses done_o high for one cycle.
- R7: ext_clr_n_i low at a clock edge sets row_o to 0 and cancels any refresh in progress, with no done_o pulse.
- R8: Commands presented while a refresh is in progress are ignored, including setup commands.
- R9: A single-step refresh never pulses done_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command: 00 none, 01 step, 10 burst, 11 setup |
| sel_i | input | 2 | Terminal-count select, read by the setup command |
| ext_clr_n_i | input | 1 | Active-low external counter clear |
| row_o | output | ROW_W (9) | Row address for the current or next refresh |
| strobe_o | output | 1 | Refresh strobe request |
| eoc_n_o | output | 1 | Active-low terminal-row flag |
| done_o | output | 1 | One-cycle pulse when a burst ends |

## Verification
A command sampled at edge E raises strobe_o in the cycle after E. strobe_o stays high for CYC_CLKS cycles per row. The new row value and the falling strobe both appear after edge E+CYC_CLKS, and done_o is high for that same single cycle. The clear acts on the next edge, and a setup takes effect on the next edge. The bench's behavioural model advances on the same edges as the design, and every output is compared against it at the falling clock edge of every cycle. Directed checks count strobe cycles per burst, so each terminal-count setting is confirmed by the burst length.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_STEP  = 2'b01,
    CMD_BURST = 2'b10,
    CMD_SETUP = 2'b11
  } rrc_cmd_e;

  // terminal-count select codes
  localparam logic [1:0] SEL_QUARTER = 2'b00;
  localparam logic [1:0] SEL_HALF    = 2'b01;
endpackage

// File: rtl/rrc_term_reg.sv
module rrc_term_reg #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [1:0]       sel_i,
  output logic [ROW_W-1:0] term_o
);
  import rrc_pkg::*;

  localparam logic [ROW_W-1:0] T_QUARTER = {2'b00, {(ROW_W-2){1'b1}}};
  localparam logic [ROW_W-1:0] T_HALF    = {1'b0, {(ROW_W-1){1'b1}}};
  localparam logic [ROW_W-1:0] T_FULL    = {ROW_W{1'b1}};

  logic [ROW_W-1:0] decoded;

  always_comb begin
    if (sel_i[1])                decoded = T_FULL;
    else if (sel_i == SEL_HALF)  decoded = T_HALF;
    else                         decoded = T_QUARTER;
  end

  always_ff @(posedge clk) begin
    if (rst)         term_o <= T_QUARTER;
    else if (load_i) term_o <= decoded;
  end

  p_term_legal_r3: assert property (@(posedge clk) disable iff (rst)
    (term_o == T_QUARTER) || (term_o == T_HALF) || (term_o == T_FULL));
endmodule

// File: rtl/rrc_row_ctr.sv
module rrc_row_ctr #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [ROW_W-1:0] term_i,
  output logic [ROW_W-1:0] row_o,
  output logic [ROW_W-1:0] row_nxt_o
);
  assign row_nxt_o = (row_o == term_i) ? '0 : row_o + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr_i) row_o <= '0;
    else if (inc_i)   row_o <= row_nxt_o;
  end

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (row_o == '0));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !inc_i) |=> $stable(row_o));
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && inc_i && row_o == term_i) |=> (row_o == '0));
endmodule

// File: rtl/rrc_refresh_seq.sv
module rrc_refresh_seq #(
  parameter int ROW_W    = 9,
  parameter int CYC_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort_i,
  input  logic [1:0]       cmd_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] row_nxt_i,
  input  logic [ROW_W-1:0] term_i,
  output logic             busy_o,
  output logic             inc_o,
  output logic             load_cfg_o,
  output logic             strobe_o,
  output logic             eoc_n_o,
  output logic             done_o
);
  import rrc_pkg::*;

  localparam int PH_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_CLKS - 1);

  logic [PH_W-1:0] phase;
  logic            burst;
  logic            at_term;
  logic            at_end;

  assign at_term    = (row_i == term_i);
  assign at_end     = busy_o && (phase == PH_LAST);
  assign inc_o      = at_end && !abort_i;
  assign load_cfg_o = !busy_o && !abort_i && (cmd_i == CMD_SETUP);

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      busy_o   <= 1'b0;
      burst    <= 1'b0;
      phase    <= '0;
      strobe_o <= 1'b0;
      eoc_n_o  <= 1'b1;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (cmd_i == CMD_STEP || cmd_i == CMD_BURST) begin
          busy_o   <= 1'b1;
          burst    <= (cmd_i == CMD_BURST);
          phase    <= '0;
          strobe_o <= 1'b1;
          eoc_n_o  <= !at_term;
        end
      end else if (at_end) begin
        if (!burst || at_term) begin
          busy_o   <= 1'b0;
          strobe_o <= 1'b0;
          eoc_n_o  <= 1'b1;
          done_o   <= burst;
        end else begin
          phase   <= '0;
          eoc_n_o <= !(row_nxt_i == term_i);
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_eoc_in_refresh_r4: assert property (@(posedge clk) disable iff (rst)
    !eoc_n_o |-> strobe_o);
  p_done_after_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!strobe_o && $past(strobe_o)));
  p_abort_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!strobe_o && !done_o));
endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
  parameter int ROW_W    = 9,
  parameter int CYC_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cmd_i,
  input  logic [1:0]       sel_i,
  input  logic             ext_clr_n_i,
  output logic [ROW_W-1:0] row_o,
  output logic             strobe_o,
  output logic             eoc_n_o,
  output logic             done_o
);
  logic             clr;
  logic             busy;
  logic             inc;
  logic             load_cfg;
  logic [ROW_W-1:0] term;
  logic [ROW_W-1:0] row_nxt;

  assign clr = !ext_clr_n_i;

  rrc_term_reg #(.ROW_W(ROW_W)) u_term (
    .clk(clk), .rst(rst), .load_i(load_cfg), .sel_i(sel_i), .term_o(term)
  );

  rrc_row_ctr #(.ROW_W(ROW_W)) u_ctr (
    .clk(clk), .rst(rst), .clr_i(clr), .inc_i(inc), .term_i(term),
    .row_o(row_o), .row_nxt_o(row_nxt)
  );

  rrc_refresh_seq #(.ROW_W(ROW_W), .CYC_CLKS(CYC_CLKS)) u_seq (
    .clk(clk), .rst(rst), .abort_i(clr), .cmd_i(cmd_i), .row_i(row_o),
    .row_nxt_i(row_nxt), .term_i(term), .busy_o(busy), .inc_o(inc),
    .load_cfg_o(load_cfg), .strobe_o(strobe_o), .eoc_n_o(eoc_n_o),
    .done_o(done_o)
  );

  p_busy_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(term));
  p_row_steady_in_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe_o && $past(strobe_o) && !$past(inc) && !$past(clr)) |-> $stable(row_o));
endmodule

// File: tb/tb_refresh_row_counter.sv
`timescale 1ns/1ps
module tb_refresh_row_counter;
  localparam int ROW_W = 9;
  localparam int CYC   = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       cmd_i;
  logic [1:0]       sel_i;
  logic             ext_clr_n_i;
  logic [ROW_W-1:0] row_o;
  logic             strobe_o, eoc_n_o, done_o;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;
  bit finished = 0;

  // behavioural reference state
  int m_row, m_term, m_left, m_done;
  bit m_burst;
  int done_seen = 0;

  refresh_row_counter #(.ROW_W(ROW_W), .CYC_CLKS(CYC)) dut (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .sel_i(sel_i),
    .ext_clr_n_i(ext_clr_n_i), .row_o(row_o), .strobe_o(strobe_o),
    .eoc_n_o(eoc_n_o), .done_o(done_o)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int term_of(input logic [1:0] s);
    if (s[1]) return 511;
    if (s == 2'b01) return 255;
    return 127;
  endfunction

  always @(posedge clk) begin
    cyc_cnt++;
    if (rst) begin
      m_row = 0; m_term = 127; m_left = 0; m_done = 0; m_burst = 0;
    end else if (!ext_clr_n_i) begin
      m_row = 0; m_left = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_left == 0) begin
        if (cmd_i == 2'b01 || cmd_i == 2'b10) begin
          m_left = CYC; m_burst = (cmd_i == 2'b10);
        end else if (cmd_i == 2'b11) begin
          m_term = term_of(sel_i);
        end
      end else begin
        m_left--;
        if (m_left == 0) begin
          bit last;
          last = (m_row == m_term);
          m_row = last ? 0 : (m_row + 1) % 512;
          if (m_burst && !last) m_left = CYC;
          else m_done = m_burst ? 1 : 0;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(row_o == m_row, "R2/R5 row", row_o, m_row);
      check(strobe_o == (m_left > 0), "R2/R6 strobe", strobe_o, m_left > 0);
      check(eoc_n_o == !(m_left > 0 && m_row == m_term), "R4 eoc_n",
            eoc_n_o, !(m_left > 0 && m_row == m_term));
      check(done_o == m_done, "R6/R9 done", done_o, m_done);
      if (done_o) done_seen++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] c, input logic [1:0] s);
    cmd_i = c; sel_i = s;
    @(negedge clk);
    cmd_i = 2'b00;
  endtask

  task automatic run_burst(output int strobes);
    strobes = 0;
    issue(2'b10, 2'b00);
    while (!done_o && strobes < 5000) begin
      if (strobe_o) strobes++;
      @(negedge clk);
    end
    idle(1);
  endtask

  initial begin
    int n;
    int d0;
    rst = 1; cmd_i = 0; sel_i = 0; ext_clr_n_i = 1;
    idle(3);
    rst = 0;
    // R1 reset state
    check(row_o == 0, "R1 row", row_o, 0);
    check(strobe_o == 0 && done_o == 0, "R1 strobe/done", strobe_o | done_o, 0);
    check(eoc_n_o == 1, "R1 eoc_n", eoc_n_o, 1);

    // R2 / R9 single steps
    d0 = done_seen;
    for (int k = 0; k < 3; k++) begin
      issue(2'b01, 2'b00);
      idle(CYC);
    end
    check(row_o == 3, "R2 row after 3 steps", row_o, 3);
    check(done_seen == d0, "R9 no done on step", done_seen - d0, 0);

    // R7 clear
    ext_clr_n_i = 0; idle(1); ext_clr_n_i = 1;
    check(row_o == 0, "R7 clear row", row_o, 0);

    // R1/R6 default terminal 127
    run_burst(n);
    check(n == 128 * CYC, "R1 default term burst", n, 128 * CYC);
    check(row_o == 0, "R5 row after burst", row_o, 0);

    // R3 select codes
    issue(2'b11, 2'b01); idle(1);
    run_burst(n);
    check(n == 256 * CYC, "R3 sel 01", n, 256 * CYC);
    issue(2'b11, 2'b10); idle(1);
    run_burst(n);
    check(n == 512 * CYC, "R3 sel 10", n, 512 * CYC);
    issue(2'b11, 2'b11); idle(1);
    run_burst(n);
    check(n == 512 * CYC, "R3 sel 11", n, 512 * CYC);
    issue(2'b11, 2'b00); idle(1);

    // R4/R5 step up to terminal row and wrap
    for (int k = 0; k < 128; k++) begin
      issue(2'b01, 2'b00);
      idle(CYC);
    end
    check(row_o == 0, "R5 wrap by steps", row_o, 0);

    // R8 setup and step ignored during burst
    cmd_i = 2'b10; @(negedge clk);
    cmd_i = 2'b11; sel_i = 2'b10; idle(5);
    cmd_i = 2'b01; idle(2);
    cmd_i = 2'b00;
    n = 7;
    while (!done_o) @(negedge clk);
    idle(1);
    run_burst(n);
    check(n == 128 * CYC, "R8 setup ignored while busy", n, 128 * CYC);

    // R7 clear mid-burst, no done
    d0 = done_seen;
    issue(2'b10, 2'b00);
    idle(40);
    ext_clr_n_i = 0; idle(1); ext_clr_n_i = 1;
    check(row_o == 0 && strobe_o == 0, "R7 abort", row_o, 0);
    idle(20);
    check(done_seen == d0, "R7 no done after abort", done_seen - d0, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc_cnt > 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule